// File: doc/BRIEF.md
# Fully Associative Tag Store with Rotating Victim Pointer

This block keeps the tags of a 64-entry fully associative cache. It has no index field, so every entry can hold any block. A lookup compares the tag of its address with every valid entry in the same cycle. It reports a hit and the number of the matching entry. The block never holds data, never fetches from memory and never handles writes. It stores only tags, valid bits and one replacement pointer.

The victim output always names one entry, the one the next fill will overwrite. The pointer does not keep a full use history. It moves forward by one when an access lands on the entry it names, and it also moves when a fill uses that entry. Any other access leaves it in place. This gives a cheap approximation of least-recently-used replacement. A fill whose tag is already held in the array is dropped, so the array never holds the same tag twice.

Top module: `fa_tag_store`

## Requirements
- R1: After synchronous reset no entry is valid, so every lookup misses, and the victim output is 0.
- R2: The tag is address bits [31:5], 27 bits. Address bits [4:0] select a byte in the 32-byte block and have no effect on hit or entry index.
- R3: The hit output is high only while the lookup valid input is high and a valid entry holds the lookup tag. A stale tag in an entry whose valid bit is clear never hits.
- R4: On a hit the index output gives the number of the matching entry (0 to 63). If several entries match, it gives the lowest number.
- R5: An accepted fill writes its tag into the entry named by the victim output and sets that entry's valid bit. From the next cycle the victim output is one higher. The tag that was in that entry before no longer hits.
- R6: A lookup that hits the entry named by the victim output moves the pointer forward by one on the next clock edge. A lookup that hits any other entry leaves the pointer unchanged, and so does a miss.
- R7: When the pointer moves forward from entry 63 it wraps to entry 0.
- R8: A fill whose tag already sits in a valid entry is ignored. Nothing is written and the pointer does not move, so no two valid entries ever hold the same tag.
- R9: When a fill and a lookup arrive in the same cycle, the lookup sees the array as it was before the fill. The pointer moves forward by one at most in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Lookup byte address |
| fill_valid | input | 1 | Fill request strobe |
| fill_addr | input | 32 | Byte address of the block to install |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 6 | Index of the entry that matched |
| victim | output | 6 | Entry the next fill will replace |

## Verification
The hardest state to reach from the ports is a pointer that sits on a valid entry, because a lookup can only move the pointer after the array has been filled all the way round. The stimulus fills 64 distinct tags, which also wraps the pointer from 63 to 0. It then looks up the entry under the pointer and also an entry away from the pointer, and checks that the pointer moves only in the first case. A duplicate fill aimed at a full array checks R8. A fill and a lookup of the same new tag in one cycle checks that the lookup sees the array from before the fill.

// File: rtl/fa_tag_pkg.sv
package fa_tag_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFS_W   = 5;
    localparam int TAG_W   = ADDR_W - OFS_W;
    localparam int ENTRIES = 64;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } entry_t;

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1:OFS_W];
    endfunction
endpackage

// File: rtl/fa_tag_cmp.sv
// Compares one key tag against every entry at once.
module fa_tag_cmp
    import fa_tag_pkg::*;
(
    input  entry_t [ENTRIES-1:0] ents,
    input  tag_t                 key,
    output logic [ENTRIES-1:0]   match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ents[g].vld && (ents[g].tag == key);
    end
endmodule

// File: rtl/fa_low_pick.sv
// Encodes a match vector to the lowest set position.
module fa_low_pick
    import fa_tag_pkg::*;
(
    input  logic [ENTRIES-1:0] vec,
    output logic               found,
    output idx_t               idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) idx = idx_t'(i);
        end
    end
endmodule

// File: rtl/fa_victim_ptr.sv
// Rotating replacement pointer; wraps naturally at ENTRIES (power of two).
module fa_victim_ptr
    import fa_tag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output idx_t ptr
);
    always_ff @(posedge clk) begin
        if (rst)          ptr <= '0;
        else if (advance) ptr <= ptr + idx_t'(1);
    end
endmodule

// File: rtl/fa_tag_store.sv
module fa_tag_store
    import fa_tag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_valid,
    input  logic [31:0] lk_addr,
    input  logic        fill_valid,
    input  logic [31:0] fill_addr,
    output logic        lk_hit,
    output logic [5:0]  lk_way,
    output logic [5:0]  victim
);
    entry_t [ENTRIES-1:0] ents;
    logic   [ENTRIES-1:0] lk_match;
    logic   [ENTRIES-1:0] fill_match;
    logic                 lk_found;
    idx_t                 lk_idx;
    idx_t                 ptr;
    logic                 fill_dup;
    logic                 fill_we;
    logic                 lk_on_ptr;

    fa_tag_cmp u_lk_cmp (
        .ents  (ents),
        .key   (tag_of(lk_addr)),
        .match (lk_match)
    );

    fa_tag_cmp u_fill_cmp (
        .ents  (ents),
        .key   (tag_of(fill_addr)),
        .match (fill_match)
    );

    fa_low_pick u_pick (
        .vec   (lk_match),
        .found (lk_found),
        .idx   (lk_idx)
    );

    assign fill_dup  = |fill_match;
    assign fill_we   = fill_valid && !fill_dup;
    assign lk_on_ptr = lk_valid && lk_match[ptr];

    fa_victim_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .advance (fill_we || lk_on_ptr),
        .ptr     (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else if (fill_we) begin
            ents[ptr] <= '{vld: 1'b1, tag: tag_of(fill_addr)};
        end
    end

    assign lk_hit = lk_valid && lk_found;
    assign lk_way = lk_idx;
    assign victim = ptr;
endmodule

// File: rtl/fa_tag_store_chk.sv
module fa_tag_store_chk
    import fa_tag_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       lk_valid,
    input logic       lk_hit,
    input logic [5:0] lk_way,
    input logic [5:0] victim,
    input logic       fill_valid,
    input logic       fill_dup
);
    // R1: pointer sits on entry 0 when reset is released
    a_r1_ptr_home: assert property (@(posedge clk)
        $fell(rst) |-> victim == 6'd0);

    // R3: no hit without a lookup request
    a_r3_idle_nohit: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !lk_hit);

    // R5: accepted fill steps the pointer by one
    a_r5_fill_step: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_dup) |=> victim == 6'($past(victim) + 6'd1));

    // R6: hit on the pointed entry steps the pointer
    a_r6_hit_step: assert property (@(posedge clk) disable iff (rst)
        (!fill_valid && lk_valid && lk_hit && lk_way == victim)
        |=> victim == 6'($past(victim) + 6'd1));

    // R6: other accesses hold the pointer
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!fill_valid && !(lk_hit && lk_way == victim)) |=> $stable(victim));

    // R8: duplicate fill with no pointer hit leaves the pointer in place
    a_r8_dup_drop: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_dup && !(lk_hit && lk_way == victim)) |=> $stable(victim));
endmodule

bind fa_tag_store fa_tag_store_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_way     (lk_way),
    .victim     (victim),
    .fill_valid (fill_valid),
    .fill_dup   (fill_dup)
);

// File: tb/fa_tag_store_bench.sv
module fa_tag_store_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        lk_hit;
    logic [5:0]  lk_way;
    logic [5:0]  victim;

    int total = 0;
    int bad = 0;

    // reference model
    logic [26:0] m_tag [N];
    logic        m_vld [N];
    int          m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    fa_tag_store u_fa_tag_store (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .lk_hit(lk_hit), .lk_way(lk_way), .victim(victim)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_find(logic [26:0] t);
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic logic [31:0] mk(logic [26:0] t, logic [4:0] ofs);
        return {t, ofs};
    endfunction

    // one lookup through one clock edge, compared against the model
    task automatic look(logic [31:0] a, string req);
        int e;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        #2;
        e = m_find(a[31:5]);
        check(req, int'(lk_hit), int'(e >= 0));
        if (e >= 0) check(req, int'(lk_way), e);
        if (e == m_ptr) m_ptr = (m_ptr + 1) % N;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(logic [31:0] a);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        @(negedge clk);
        fill_valid = 1'b0;
        if (m_find(a[31:5]) < 0) begin
            m_tag[m_ptr] = a[31:5];
            m_vld[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % N;
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; end
        m_ptr = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 victim after reset", int'(victim), 0);
        look(32'h0000_0000, "R1 empty lookup");
        look(32'hDEAD_BEE0, "R1 empty lookup");
    endtask

    task automatic t_basic();
        fill(mk(27'h0A000, 5'h00));
        fill(mk(27'h0A001, 5'h00));
        fill(mk(27'h0A002, 5'h00));
        check("R5 victim after three fills", int'(victim), 3);
        look(mk(27'h0A000, 5'h1F), "R2 offset ignored");
        look(mk(27'h0A001, 5'h04), "R4 index of entry 1");
        look(mk(27'h0A002, 5'h11), "R2 R4 entry 2");
        check("R6 off-pointer hits keep victim", int'(victim), 3);
    endtask

    task automatic t_idle();
        @(negedge clk);
        lk_valid = 1'b0;
        lk_addr  = mk(27'h0A000, 5'h00);
        #2;
        check("R3 no hit without request", int'(lk_hit), 0);
        look(mk(27'h0B000, 5'h00), "R3 unknown tag misses");
        check("R6 miss keeps victim", int'(victim), 3);
    endtask

    task automatic t_wrap();
        for (int i = 3; i < N; i++) fill(mk(27'h0A000 + 27'(i), 5'h00));
        check("R7 victim wraps to 0", int'(victim), 0);
    endtask

    task automatic t_ptr();
        look(mk(27'h0A000, 5'h08), "R6 hit on pointed entry");
        check("R6 victim stepped", int'(victim), 1);
        look(mk(27'h0A005, 5'h00), "R6 hit elsewhere");
        check("R6 victim held", int'(victim), 1);
    endtask

    task automatic t_dup();
        fill(mk(27'h0A007, 5'h03));
        check("R8 duplicate fill keeps victim", int'(victim), 1);
        look(mk(27'h0A007, 5'h00), "R8 tag stays in entry 7");
        look(mk(27'h0A001, 5'h00), "R8 entry under pointer intact");
        check("R6 victim after pointer hit", int'(victim), 2);
    endtask

    task automatic t_same();
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = mk(27'h0C000, 5'h00);
        lk_valid   = 1'b1;
        lk_addr    = mk(27'h0C000, 5'h02);
        #2;
        check("R9 lookup sees old array", int'(lk_hit), 0);
        @(negedge clk);
        fill_valid = 1'b0;
        lk_valid   = 1'b0;
        m_tag[2] = 27'h0C000;
        m_ptr = 3;
        check("R9 single pointer step", int'(victim), 3);
        look(mk(27'h0C000, 5'h00), "R9 new tag in entry 2");
        look(mk(27'h0A002, 5'h00), "R5 evicted tag misses");
    endtask

    task automatic t_scan();
        for (int i = 0; i < N; i++)
            if (m_vld[i]) look({m_tag[i], 5'h00}, "R4 full scan");
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
                if (m_vld[i] && m_vld[j])
                    check("R8 no duplicate tags", int'(m_tag[i] == m_tag[j]), 0);
        check("R6 R7 victim tracks model", int'(victim), m_ptr);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_idle();
        t_wrap();
        t_ptr();
        t_dup();
        t_same();
        t_scan();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule